// File: doc/BRIEF.md
# Retention Experiment Test Scheduler

This block sequences a long retention experiment. It hands one test at a time to a downstream test sequencer, which writes a data pattern, suspends refresh for a given number of refresh loops, and reads the data back. For each test the scheduler presents the round number, the pattern index, a flag that selects the bitwise inverse of that pattern, and the wait length in refresh loops. It pulses a request and then waits for the sequencer to report completion.

The tests are ordered as nested loops. The innermost loop is a pair: a pattern and then its inverse at the same wait. The next loop covers every pattern. The next one sweeps the wait from its lowest value to its highest. The outer loop repeats that sweep over a number of rounds. If the retention of a cell shifts at random during the run, the shift lands between whole sweeps and stays separate from any effect of the stored pattern. The round number goes to the pattern generator, so that patterns which change from round to round can advance. The round count is meant to be a multiple of 16, so that a pattern rotating once per round returns to its starting phase.

Top module: `rts_top`

## Requirements
- R1: After reset the block is idle. The request and experiment-done outputs are low, round, pattern and invert read 0, and the wait reads WAIT_MIN.
- R2: A start pulse while idle or finished resets the parameters to the first test (round 0, pattern 0, invert 0, wait WAIT_MIN). It also clears experiment-done and raises the request in the cycle after the start edge.
- R3: The request is high for exactly one cycle per test. No new request appears until the sequencer's done has been seen. A done pulse that arrives while no test is outstanding has no effect.
- R4: Every test with invert=0 is followed by a test with invert=1 that has the same pattern, wait and round.
- R5: After the invert=1 test of a pattern, the pattern index advances by one, up to NUM_PAT-1, and the wait does not change.
- R6: After the last pattern, the wait rises by WAIT_STEP, from WAIT_MIN up to the highest reachable value not above WAIT_MAX. From there it wraps to WAIT_MIN.
- R7: The round number advances by one each time the wait wraps, and counts from 0 to NUM_ROUNDS-1.
- R8: Experiment-done rises in the cycle after the done of the final test (last round, last wait, last pattern, invert=1). It stays high, with no request, until the next start.
- R9: A start pulse while tests are still being run is ignored, and the sequence continues unchanged.
- R10: Round, pattern, invert and wait stay stable from a request until the matching done is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new experiment |
| seq_done_i | input | 1 | Test sequencer has finished the current test |
| test_req_o | output | 1 | One-cycle pulse: launch the test described by the outputs |
| round_o | output | ROUND_W | Current round number |
| pattern_o | output | PAT_W | Current pattern index |
| invert_o | output | 1 | 1 selects the bitwise inverse of the pattern |
| wait_loops_o | output | WAIT_W | Refresh-suspended wait, in refresh loops |
| exp_done_o | output | 1 | Whole experiment finished |

## Verification
The hardest state to reach is the final test. Only the one done that arrives when all four counters sit at their limits may raise experiment-done. To reach it, the bench acts as the sequencer and plays out the entire default experiment of 4736 tests. It uses varying done latencies, and checks every request against an order computed from nested loops in the bench. One start pulse is placed in the middle of the run to show that it has no effect. Stray done pulses are sent both before the first start and after completion.

// File: rtl/rts_pkg.sv
package rts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } rts_state_e;

    typedef struct packed {
        rts_state_e state;
        logic       fin;
    } rts_ctrl_s;
endpackage

// File: rtl/rts_step_ctr.sv
module rts_step_ctr #(
    parameter int W    = 4,
    parameter int MIN  = 0,
    parameter int LAST = 15,
    parameter int STEP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic         last_o
);
    localparam logic [W-1:0] V_MIN  = W'(MIN);
    localparam logic [W-1:0] V_LAST = W'(LAST);
    localparam logic [W-1:0] V_STEP = W'(STEP);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr_i)
            val_d = V_MIN;
        else if (inc_i)
            val_d = (val_q == V_LAST) ? V_MIN : val_q + V_STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= V_MIN;
        else        val_q <= val_d;
    end

    assign val_o  = val_q;
    assign last_o = (val_q == V_LAST);

    // R6/R7: counter never passes its last value
    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        val_o <= V_LAST);
    // R6/R7: a non-final increment moves by one step
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && !last_o) |=> (val_o == $past(val_o) + V_STEP));
    // R6/R7: increment at the last value wraps to the first
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && last_o) |=> (val_o == V_MIN));
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
    import rts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic seq_done_i,
    input  logic final_i,
    output logic clr_o,
    output logic adv_o,
    output logic req_o,
    output logic waiting_o,
    output logic fin_o
);
    rts_ctrl_s c_d, c_q;

    always_comb begin
        c_d   = c_q;
        clr_o = 1'b0;
        adv_o = 1'b0;
        unique case (c_q.state)
            ST_IDLE, ST_FIN: begin
                if (start_i) begin
                    clr_o     = 1'b1;
                    c_d.fin   = 1'b0;
                    c_d.state = ST_ISSUE;
                end
            end
            ST_ISSUE: c_d.state = ST_WAIT;
            ST_WAIT: begin
                if (seq_done_i) begin
                    if (final_i) begin
                        c_d.state = ST_FIN;
                        c_d.fin   = 1'b1;
                    end else begin
                        adv_o     = 1'b1;
                        c_d.state = ST_ISSUE;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, fin: 1'b0};
        else        c_q <= c_d;
    end

    assign req_o     = (c_q.state == ST_ISSUE);
    assign waiting_o = (c_q.state == ST_WAIT);
    assign fin_o     = c_q.fin;

    // R3: request lasts a single cycle
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R3: no request while a test is outstanding and done is absent
    a_r3_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_o && !seq_done_i) |=> (waiting_o && !req_o));
    // R8: finished flag holds until a start arrives
    a_r8_fin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && !start_i) |=> (fin_o && !req_o));
    // R9: start while running does not clear the sequence
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && waiting_o) |-> !clr_o);
endmodule

// File: rtl/rts_top.sv
module rts_top #(
    parameter int NUM_PAT    = 4,
    parameter int WAIT_MIN   = 23,
    parameter int WAIT_MAX   = 95,
    parameter int WAIT_STEP  = 2,
    parameter int NUM_ROUNDS = 16,
    localparam int PAT_W     = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1,
    localparam int WAIT_W    = $clog2(WAIT_MAX + 1),
    localparam int ROUND_W   = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               seq_done_i,
    output logic               test_req_o,
    output logic [ROUND_W-1:0] round_o,
    output logic [PAT_W-1:0]   pattern_o,
    output logic               invert_o,
    output logic [WAIT_W-1:0]  wait_loops_o,
    output logic               exp_done_o
);
    localparam int WAIT_LAST = WAIT_MIN + ((WAIT_MAX - WAIT_MIN) / WAIT_STEP) * WAIT_STEP;

    logic clr, adv, waiting, final_test;
    logic inv_last, pat_last, wait_last, round_last;
    logic inc_pat, inc_wait, inc_round;

    assign inc_pat    = adv && inv_last;
    assign inc_wait   = inc_pat && pat_last;
    assign inc_round  = inc_wait && wait_last;
    assign final_test = inv_last && pat_last && wait_last && round_last;

    rts_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_done_i(seq_done_i),
        .final_i(final_test), .clr_o(clr), .adv_o(adv), .req_o(test_req_o),
        .waiting_o(waiting), .fin_o(exp_done_o)
    );

    rts_step_ctr #(.W(1), .MIN(0), .LAST(1), .STEP(1)) u_inv (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(adv),
        .val_o(invert_o), .last_o(inv_last)
    );

    rts_step_ctr #(.W(PAT_W), .MIN(0), .LAST(NUM_PAT - 1), .STEP(1)) u_pat (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(inc_pat),
        .val_o(pattern_o), .last_o(pat_last)
    );

    rts_step_ctr #(.W(WAIT_W), .MIN(WAIT_MIN), .LAST(WAIT_LAST), .STEP(WAIT_STEP)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(inc_wait),
        .val_o(wait_loops_o), .last_o(wait_last)
    );

    rts_step_ctr #(.W(ROUND_W), .MIN(0), .LAST(NUM_ROUNDS - 1), .STEP(1)) u_round (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(inc_round),
        .val_o(round_o), .last_o(round_last)
    );

    // R10: parameters frozen while a test is outstanding
    a_r10_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !seq_done_i) |=> ($stable(round_o) && $stable(pattern_o)
                                      && $stable(invert_o) && $stable(wait_loops_o)));
    // R4: the inverse test keeps pattern, wait and round of its partner
    a_r4_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !invert_o) |=> (invert_o && $stable(pattern_o)
                                && $stable(wait_loops_o) && $stable(round_o)));
    // R8: completion comes only from the final test's done
    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exp_done_o) |-> $past(waiting && seq_done_i && final_test));
endmodule

// File: tb/sim_rts_top.sv
module sim_rts_top;
    localparam int NP = 4, WMIN = 23, WMAX = 95, WST = 2, NR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       seq_done_i = 1'b0;
    logic       test_req_o, invert_o, exp_done_o;
    logic [3:0] round_o;
    logic [1:0] pattern_o;
    logic [6:0] wait_loops_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rts_top #(.NUM_PAT(NP), .WAIT_MIN(WMIN), .WAIT_MAX(WMAX), .WAIT_STEP(WST),
              .NUM_ROUNDS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_done_i(seq_done_i),
        .test_req_o(test_req_o), .round_o(round_o), .pattern_o(pattern_o),
        .invert_o(invert_o), .wait_loops_o(wait_loops_o), .exp_done_o(exp_done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int params();
        return {16'(round_o), 8'(pattern_o), 1'(invert_o), 7'(wait_loops_o)};
    endfunction

    function automatic int pack(int r, int p, int c, int w);
        return {16'(r), 8'(p), 1'(c), 7'(w)};
    endfunction

    task automatic wait_req(output bit ok);
        ok = test_req_o;
        for (int i = 0; i < 50 && !ok; i++) begin
            @(negedge clk);
            ok = test_req_o;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!test_req_o && !exp_done_o, "R1 req/done low", {test_req_o, exp_done_o}, 0);
        chk(params() == pack(0, 0, 0, WMIN), "R1 reset params", params(), pack(0, 0, 0, WMIN));
    endtask

    task automatic t_stray_done();
        seq_done_i = 1'b1;
        @(negedge clk);
        seq_done_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!test_req_o, "R3 stray done no request", test_req_o, 0);
        end
        chk(params() == pack(0, 0, 0, WMIN), "R3 stray done no change", params(), pack(0, 0, 0, WMIN));
    endtask

    task automatic t_full_run();
        int idx = 0;
        bit ok;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(test_req_o, "R2 request after start", test_req_o, 1);
        for (int r = 0; r < NR; r++)
            for (int w = WMIN; w <= WMAX; w += WST)
                for (int p = 0; p < NP; p++)
                    for (int c = 0; c < 2; c++) begin
                        int exp = pack(r, p, c, w);
                        int got;
                        wait_req(ok);
                        chk(ok, "R3 request arrives", ok, 1);
                        got = params();
                        // R4 R5 R6 R7: order of tests
                        chk(got == exp, "R4/R5/R6/R7 test order", got, exp);
                        @(negedge clk);
                        chk(!test_req_o, "R3 single-cycle request", test_req_o, 0);
                        if (idx == 101) start_i = 1'b1;   // R9 start while running
                        for (int d = 0; d < idx % 3; d++) @(negedge clk);
                        start_i = 1'b0;
                        chk(params() == exp, "R10 params held", params(), exp);
                        chk(!exp_done_o, "R8 not done early", exp_done_o, 0);
                        seq_done_i = 1'b1;
                        @(negedge clk);
                        seq_done_i = 1'b0;
                        idx++;
                    end
        chk(exp_done_o, "R8 done after final test", exp_done_o, 1);
        chk(!test_req_o, "R8 no request after final", test_req_o, 0);
    endtask

    task automatic t_hold();
        seq_done_i = 1'b1;
        @(negedge clk);
        seq_done_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(exp_done_o && !test_req_o, "R8 done holds, R3 stray done", {exp_done_o, test_req_o}, 2);
        end
    endtask

    task automatic t_restart();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(test_req_o, "R2 restart request", test_req_o, 1);
        chk(!exp_done_o, "R2 restart clears done", exp_done_o, 0);
        chk(params() == pack(0, 0, 0, WMIN), "R2 restart first test", params(), pack(0, 0, 0, WMIN));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stray_done();
        t_full_run();
        t_hold();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule